// File: doc/BRIEF.md
# Shared Memory Concurrent-Write Arbiter

This block is a small register-file memory shared by several processor ports. In any cycle each port may read one cell, write one cell, or both. A run-time access mode decides which same-cell collisions are legal: a fully exclusive mode, a shared-read mode, or a shared-read-and-write mode. In the shared-write mode a second selector chooses how several writes to one cell are merged. The options are agreement checking, a fixed pick, a rank pick, or a reduction by wrapping sum, bitwise AND or unsigned maximum.

Each port gets back registered read data and a one-cycle error flag. Read data shows the cell as it stood before the cycle's writes. An illegal collision leaves the cell untouched and raises the error flag of every port that took part in it. Cells that no collision touches commit normally in the same cycle.

Top module: `shmem_crcw_arbiter`

## Requirements
- R1: While rstN is low and after it rises, every cell holds 0, every rdData lane is 0 and portErr is 0.
- R2: A read issued with rdEn[p] in one cycle shows up on rdData lane p after the next rising edge. It carries the cell contents from before any write of that same cycle.
- R3: With accMode=0 (exclusive), every port whose read or write targets a cell that another port also reads or writes in that cycle gets portErr. Writes to that cell are dropped, and reads still return the old contents.
- R4: With accMode=1 (shared read), several reads of one cell are legal. When two or more ports write one cell, each of those writers gets portErr and the cell keeps its old value.
- R5: With accMode=1, 2 or 3 (3 acts as 2), a port that only reads never gets portErr, however many ports read the same cell.
- R6: With accMode=2 and wrPolicy=0 (agree), colliding writes that all carry one value commit that value. If any two of them differ, every writer of that cell gets portErr and the cell is unchanged.
- R7: With accMode=2 and wrPolicy=1 (any-one), the value of the lowest-indexed colliding writer is stored and the rest are dropped without error.
- R8: With accMode=2 and wrPolicy=2 (rank; 6 and 7 act the same), port 0 has the best rank, so the lowest-indexed colliding writer wins.
- R9: With accMode=2 and wrPolicy=3, the cell receives the sum of all colliding write values modulo 2^DATA_W.
- R10: With accMode=2 and wrPolicy=4, the cell receives the bitwise AND of all colliding write values.
- R11: With accMode=2 and wrPolicy=5, the cell receives the unsigned maximum of all colliding write values.
- R12: portErr is registered, is high for exactly the cycle after the offending access, and flags only the ports involved. A port that is the only one touching its cell always commits without error, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accMode | input | 2 | Access discipline: 0 exclusive, 1 shared read, 2/3 shared read and write |
| wrPolicy | input | 3 | Merge rule: 0 agree, 1 any-one, 2 rank, 3 sum, 4 AND, 5 max, 6/7 rank |
| rdEn | input | NUM_PORTS | Read request per port |
| wrEn | input | NUM_PORTS | Write request per port |
| addr | input | NUM_PORTS*ADDR_W | Cell index per port, port p in bits [p*ADDR_W +: ADDR_W] |
| wrData | input | NUM_PORTS*DATA_W | Write value per port, port p in bits [p*DATA_W +: DATA_W] |
| rdData | output | NUM_PORTS*DATA_W | Registered read data per port, same lane layout as wrData |
| portErr | output | NUM_PORTS | Registered one-cycle illegal-access flag per port |

## Verification
Two functions can fall in the same cycle. The first is a port reading a cell while another port writes or merges into it: the read must show the old value, and a later read shows the committed one. The second is an illegal collision on one cell while a legal lone write commits to a different cell. Vectors provoke both on purpose: exclusive mode mixes a colliding pair with a lone writer, and agree mode puts a failed merge next to readers. Each is judged from the error mask on the next cycle and from follow-up reads of both cells.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

  typedef enum logic [1:0] {
    ACC_EXCL     = 2'd0,
    ACC_SHRD_RD  = 2'd1,
    ACC_SHRD_ALL = 2'd2,
    ACC_SHRD_ALT = 2'd3
  } accMode_e;

  typedef enum logic [2:0] {
    POL_AGREE = 3'd0,
    POL_ANY   = 3'd1,
    POL_RANK  = 3'd2,
    POL_SUM   = 3'd3,
    POL_AND   = 3'd4,
    POL_MAX   = 3'd5,
    POL_RSV6  = 3'd6,
    POL_RSV7  = 3'd7
  } wrPolicy_e;

  typedef enum logic [1:0] {
    MRG_FIRST = 2'd0,
    MRG_SUM   = 2'd1,
    MRG_AND   = 2'd2,
    MRG_MAX   = 2'd3
  } mergeOp_e;

  typedef struct packed {
    mergeOp_e mergeOp;
  } ctrlStrobe_t;

endpackage

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
  import shmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic [1:0]                  accMode,
  input  logic [2:0]                  wrPolicy,
  input  logic [NUM_PORTS-1:0]        rdEn,
  input  logic [NUM_PORTS-1:0]        wrEn,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr,
  input  logic [NUM_PORTS*DATA_W-1:0] wrData,
  output ctrlStrobe_t                 strobe,
  output logic [DEPTH-1:0]            cellWe,
  output logic [NUM_PORTS-1:0]        errNow
);

  logic [NUM_PORTS-1:0] touchHit;
  logic [NUM_PORTS-1:0] wrHit;
  logic [NUM_PORTS-1:0] valDiff;
  logic [NUM_PORTS-1:0] touching;

  assign touching = rdEn | wrEn;

  // pairwise collision scan
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      touchHit[p] = 1'b0;
      wrHit[p]    = 1'b0;
      valDiff[p]  = 1'b0;
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q != p && addr[p*ADDR_W +: ADDR_W] == addr[q*ADDR_W +: ADDR_W]) begin
          if (touching[p] && touching[q]) touchHit[p] = 1'b1;
          if (wrEn[p] && wrEn[q]) begin
            wrHit[p] = 1'b1;
            if (wrData[p*DATA_W +: DATA_W] != wrData[q*DATA_W +: DATA_W])
              valDiff[p] = 1'b1;
          end
        end
      end
    end
  end

  // per-port violation under the active discipline
  always_comb begin
    unique case (accMode_e'(accMode))
      ACC_EXCL:    errNow = touchHit;
      ACC_SHRD_RD: errNow = wrHit;
      default:     errNow = (wrPolicy_e'(wrPolicy) == POL_AGREE) ? valDiff : '0;
    endcase
  end

  // a cell commits when written and no writer of it is in violation
  always_comb begin
    for (int c = 0; c < DEPTH; c++) begin
      logic anyWr;
      logic anyBad;
      anyWr  = 1'b0;
      anyBad = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wrEn[p] && addr[p*ADDR_W +: ADDR_W] == ADDR_W'(c)) begin
          anyWr  = 1'b1;
          anyBad = anyBad | errNow[p];
        end
      end
      cellWe[c] = anyWr && !anyBad;
    end
  end

  // merge selection; outside shared-write mode only lone writers commit
  always_comb begin
    strobe.mergeOp = MRG_FIRST;
    if (accMode[1]) begin
      unique case (wrPolicy_e'(wrPolicy))
        POL_SUM: strobe.mergeOp = MRG_SUM;
        POL_AND: strobe.mergeOp = MRG_AND;
        POL_MAX: strobe.mergeOp = MRG_MAX;
        default: strobe.mergeOp = MRG_FIRST;
      endcase
    end
  end

endmodule

// File: rtl/shmem_merge.sv
module shmem_merge
  import shmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int CELL      = 0
) (
  input  mergeOp_e                    mergeOp,
  input  logic [NUM_PORTS-1:0]        wrEn,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr,
  input  logic [NUM_PORTS*DATA_W-1:0] wrData,
  output logic [DATA_W-1:0]           cellVal
);

  logic [DATA_W-1:0] firstVal;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] andVal;
  logic [DATA_W-1:0] maxVal;

  always_comb begin
    firstVal = '0;
    sumVal   = '0;
    andVal   = '1;
    maxVal   = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (wrEn[p] && addr[p*ADDR_W +: ADDR_W] == ADDR_W'(CELL)) begin
        firstVal = wrData[p*DATA_W +: DATA_W];
        sumVal   = sumVal + wrData[p*DATA_W +: DATA_W];
        andVal   = andVal & wrData[p*DATA_W +: DATA_W];
        if (wrData[p*DATA_W +: DATA_W] > maxVal) maxVal = wrData[p*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    unique case (mergeOp)
      MRG_SUM: cellVal = sumVal;
      MRG_AND: cellVal = andVal;
      MRG_MAX: cellVal = maxVal;
      default: cellVal = firstVal;
    endcase
  end

endmodule

// File: rtl/shmem_data.sv
module shmem_data
  import shmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [DEPTH-1:0]            cellWe,
  input  logic [NUM_PORTS-1:0]        errNow,
  input  logic [NUM_PORTS-1:0]        rdEn,
  input  logic [NUM_PORTS-1:0]        wrEn,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr,
  input  logic [NUM_PORTS*DATA_W-1:0] wrData,
  output logic [NUM_PORTS*DATA_W-1:0] rdData,
  output logic [NUM_PORTS-1:0]        portErr
);

  logic [DATA_W-1:0] mem     [DEPTH];
  logic [DATA_W-1:0] cellVal [DEPTH];

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    shmem_merge #(
      .NUM_PORTS(NUM_PORTS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .CELL     (c)
    ) i_merge (
      .mergeOp(strobe.mergeOp),
      .wrEn   (wrEn),
      .addr   (addr),
      .wrData (wrData),
      .cellVal(cellVal[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < DEPTH; c++) mem[c] <= '0;
    end else begin
      for (int c = 0; c < DEPTH; c++)
        if (cellWe[c]) mem[c] <= cellVal[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      portErr <= '0;
    end else begin
      portErr <= errNow;
      for (int p = 0; p < NUM_PORTS; p++)
        if (rdEn[p]) rdData[p*DATA_W +: DATA_W] <= mem[addr[p*ADDR_W +: ADDR_W]];
    end
  end

endmodule

// File: rtl/shmem_crcw_arbiter.sv
module shmem_crcw_arbiter
  import shmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  accMode,
  input  logic [2:0]                  wrPolicy,
  input  logic [NUM_PORTS-1:0]        rdEn,
  input  logic [NUM_PORTS-1:0]        wrEn,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr,
  input  logic [NUM_PORTS*DATA_W-1:0] wrData,
  output logic [NUM_PORTS*DATA_W-1:0] rdData,
  output logic [NUM_PORTS-1:0]        portErr
);

  ctrlStrobe_t          strobe;
  logic [DEPTH-1:0]     cellWe;
  logic [NUM_PORTS-1:0] errNow;

  shmem_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W)
  ) i_ctrl (
    .accMode (accMode),
    .wrPolicy(wrPolicy),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .strobe  (strobe),
    .cellWe  (cellWe),
    .errNow  (errNow)
  );

  shmem_data #(
    .NUM_PORTS(NUM_PORTS),
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .ADDR_W   (ADDR_W)
  ) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cellWe (cellWe),
    .errNow (errNow),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .portErr(portErr)
  );

endmodule

// File: rtl/shmem_crcw_chk.sv
module shmem_crcw_chk #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 3
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [1:0]                  accMode,
  input logic [2:0]                  wrPolicy,
  input logic [NUM_PORTS-1:0]        rdEn,
  input logic [NUM_PORTS-1:0]        wrEn,
  input logic [NUM_PORTS*ADDR_W-1:0] addr,
  input logic [NUM_PORTS-1:0]        portErr
);

  AST_NO_MERGE_ERR: assert property (@(posedge clk) disable iff (!rstN) // R7
    (accMode[1] && wrPolicy != 3'd0) |=> (portErr == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN) // R12
      (!rdEn[p] && !wrEn[p]) |=> !portErr[p]);

    AST_SHARED_READ_OK: assert property (@(posedge clk) disable iff (!rstN) // R5
      (accMode != 2'd0 && rdEn[p] && !wrEn[p]) |=> !portErr[p]);

    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      AST_EXCL_PAIR_ERR: assert property (@(posedge clk) disable iff (!rstN) // R3
        (accMode == 2'd0 && (rdEn[p] || wrEn[p]) && (rdEn[q] || wrEn[q]) &&
         addr[p*ADDR_W +: ADDR_W] == addr[q*ADDR_W +: ADDR_W])
        |=> (portErr[p] && portErr[q]));

      AST_DOUBLE_WRITE_ERR: assert property (@(posedge clk) disable iff (!rstN) // R4
        (accMode == 2'd1 && wrEn[p] && wrEn[q] &&
         addr[p*ADDR_W +: ADDR_W] == addr[q*ADDR_W +: ADDR_W])
        |=> (portErr[p] && portErr[q]));
    end
  end

endmodule

bind shmem_crcw_arbiter shmem_crcw_chk #(
  .NUM_PORTS(NUM_PORTS),
  .ADDR_W   (ADDR_W)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .accMode (accMode),
  .wrPolicy(wrPolicy),
  .rdEn    (rdEn),
  .wrEn    (wrEn),
  .addr    (addr),
  .portErr (portErr)
);

// File: tb/test_shmem_crcw_arbiter.sv
module test_shmem_crcw_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [1:0]     mode;
    logic [2:0]     pol;
    logic [NP-1:0]  rd;
    logic [NP-1:0]  wr;
    logic [NP*AW-1:0] ad;
    logic [NP*DW-1:0] wd;
    logic [NP-1:0]  expErr;
    logic [NP*DW-1:0] expRd;
  } vec_t;

  // lanes written port3..port0
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 3'd2, 4'b0000, 4'b1111, {3'd4,3'd3,3'd2,3'd1}, {8'd44,8'd33,8'd22,8'd11}, 4'b0000, 32'd0},
    '{2'd1, 3'd0, 4'b1111, 4'b0000, {3'd3,3'd2,3'd1,3'd1}, 32'd0, 4'b0000, {8'd33,8'd22,8'd11,8'd11}},
    '{2'd1, 3'd0, 4'b0100, 4'b0011, {3'd0,3'd5,3'd5,3'd5}, {8'd0,8'd0,8'd66,8'd55}, 4'b0011, 32'd0},
    '{2'd0, 3'd0, 4'b1011, 4'b0100, {3'd4,3'd6,3'd1,3'd1}, {8'd0,8'd77,8'd0,8'd0}, 4'b0011, {8'd44,8'd0,8'd11,8'd11}},
    '{2'd0, 3'd0, 4'b0110, 4'b0001, {3'd0,3'd6,3'd1,3'd1}, {8'd0,8'd0,8'd0,8'd99}, 4'b0011, {8'd0,8'd77,8'd11,8'd0}},
    '{2'd2, 3'd0, 4'b0000, 4'b1111, {3'd3,3'd2,3'd2,3'd2}, {8'd8,8'd5,8'd5,8'd5}, 4'b0000, 32'd0},
    '{2'd2, 3'd0, 4'b1100, 4'b0011, {3'd3,3'd2,3'd2,3'd2}, {8'd0,8'd0,8'd10,8'd9}, 4'b0011, {8'd8,8'd5,8'd0,8'd0}},
    '{2'd2, 3'd1, 4'b0001, 4'b1110, {3'd4,3'd4,3'd4,3'd4}, {8'd3,8'd2,8'd1,8'd0}, 4'b0000, {8'd0,8'd0,8'd0,8'd44}},
    '{2'd2, 3'd2, 4'b0011, 4'b1100, {3'd5,3'd5,3'd2,3'd4}, {8'd7,8'd6,8'd0,8'd0}, 4'b0000, {8'd0,8'd0,8'd5,8'd1}},
    '{2'd2, 3'd3, 4'b0000, 4'b1111, {3'd6,3'd6,3'd6,3'd6}, {8'd20,8'd50,8'd100,8'd100}, 4'b0000, 32'd0},
    '{2'd2, 3'd4, 4'b1100, 4'b0011, {3'd5,3'd6,3'd7,3'd7}, {8'd0,8'd0,8'h3C,8'hF0}, 4'b0000, {8'd6,8'd14,8'd0,8'd0}},
    '{2'd2, 3'd5, 4'b1000, 4'b0111, {3'd7,3'd0,3'd0,3'd0}, {8'd0,8'd90,8'd200,8'd10}, 4'b0000, {8'h30,8'd0,8'd0,8'd0}},
    '{2'd2, 3'd2, 4'b1111, 4'b0000, {3'd7,3'd6,3'd0,3'd0}, 32'd0, 4'b0000, {8'h30,8'd14,8'd200,8'd200}},
    '{2'd2, 3'd3, 4'b0010, 4'b0001, {3'd0,3'd0,3'd3,3'd3}, {8'd0,8'd0,8'd0,8'h21}, 4'b0000, {8'd0,8'd0,8'd8,8'd0}},
    '{2'd1, 3'd0, 4'b1011, 4'b0100, {3'd1,3'd1,3'd3,3'd3}, {8'd0,8'h42,8'd0,8'd0}, 4'b0000, {8'd11,8'd0,8'h21,8'h21}}
  };

  localparam string TAGS [NVEC] = '{
    "R12", "R2", "R4", "R3", "R3", "R6", "R6", "R7",
    "R8", "R9", "R10", "R11", "R5", "R2", "R4"
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [1:0]     accMode = '0;
  logic [2:0]     wrPolicy = '0;
  logic [NP-1:0]  rdEn = '0;
  logic [NP-1:0]  wrEn = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*DW-1:0] wrData = '0;
  logic [NP*DW-1:0] rdData;
  logic [NP-1:0]  portErr;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shmem_crcw_arbiter #(.NUM_PORTS(NP), .DATA_W(DW), .DEPTH(8)) i_shmem_crcw_arbiter (
    .clk(clk), .rstN(rstN), .accMode(accMode), .wrPolicy(wrPolicy),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .portErr(portErr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    accMode = v.mode; wrPolicy = v.pol; rdEn = v.rd; wrEn = v.wr;
    addr = v.ad; wrData = v.wd;
  endtask

  task automatic idle();
    rdEn = '0; wrEn = '0; addr = '0; wrData = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rdData in reset", 32'(rdData), 32'd0);
    check("R1", "portErr in reset", 32'(portErr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "portErr after reset", 32'(portErr), 32'd0);

    drive(VECS[0]);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      check(TAGS[i], $sformatf("vec %0d portErr", i), 32'(portErr), 32'(VECS[i].expErr));
      for (int p = 0; p < NP; p++)
        if (VECS[i].rd[p])
          check(TAGS[i], $sformatf("vec %0d rdData port %0d", i, p),
                32'(rdData[p*DW +: DW]), 32'(VECS[i].expRd[p*DW +: DW]));
      if (i + 1 < NVEC) drive(VECS[i+1]);
      else idle();
    end

    // R12: error pulse lasts one cycle
    accMode = 2'd1; wrPolicy = 3'd0;
    wrEn = 4'b1001; addr = {3'd2, 3'd0, 3'd0, 3'd2}; wrData = {8'd1, 8'd0, 8'd0, 8'd2};
    @(negedge clk);
    idle();
    check("R12", "error raised", 32'(portErr), 32'b1001);
    @(negedge clk);
    check("R12", "error cleared next cycle", 32'(portErr), 32'd0);

    // R1: reset mid-run clears cells and read data
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "rdData during reset", 32'(rdData), 32'd0);
    rstN = 1'b1;
    rdEn = 4'b0011; addr = {3'd0, 3'd0, 3'd1, 3'd6};
    @(negedge clk);
    idle();
    check("R1", "cell 6 cleared", 32'(rdData[0 +: DW]), 32'd0);
    check("R1", "cell 1 cleared", 32'(rdData[DW +: DW]), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule